// File: doc/BRIEF.md
# Vector Length State Register

This block holds the loop-control state of a vector unit in one 32-bit register. The fields are the maximum vector length, the current vector length, the source and destination element offsets, the sub-vector group size and the sub-vector destination offset. Both lengths are stored as their value minus one. A length field of 0 therefore means one element, and a 6-bit field can express lengths up to 64.

Software reaches the state through four write operations, and each one sanitises its input:
- A raw full-word write clamps the length fields and drops the reserved bits.
- A set-length request clamps the requested length to the range 1 to the current maximum and returns the granted length at once.
- A set-maximum request clamps the requested maximum to the range 1 to XLEN and returns it. It also pulls the current length down if that length now exceeds the maximum.
- A group-size request accepts only 1 to 4. Any other value raises a one-cycle illegal flag and leaves the register alone.

On a trap entry or a trap return, the register swaps its whole contents with a saved copy kept for the privilege level being entered or left.

Top module: `vlst_state_csr`

## Requirements
- R1: `rdata` presents the register as: [5:0] maximum length minus one, [11:6] vector length minus one, [17:12] source offset, [23:18] destination offset, [25:24] group-size code, [27:26] sub-vector destination offset, and [31:28] reserved, which always reads 0.
- R2: After reset, `rdata` is 0 (maximum 1, length 1, group size 1, all offsets 0), `len_result` is 0 and `subvl_illegal` is 0.
- R3: With `setvl_en`, the granted length is min(`req_val`, maximum) when `req_val` is nonzero. `len_result` shows the granted length in the same cycle, and from the next cycle bits [11:6] hold that length minus one.
- R4: A set-length request of 0 grants a length of 1.
- R5: With `setmvl_en`, the granted maximum is `req_val` clamped to the range 1 to XLEN. It appears on `len_result` in the same cycle and in bits [5:0] minus one from the next cycle. The stored length becomes min(old length, new maximum).
- R6: With `wr_en`, the register takes `wr_data` with three corrections: the maximum field saturates at XLEN-1, the length field saturates at the resulting maximum field, and the reserved bits are written as 0. All other fields are stored unchanged.
- R7: With `subvl_en`, a `req_val` of 1, 2, 3 or 4 stores code 00, 01, 10 or 11 in bits [25:24]. Any other value drives `subvl_illegal` high in that cycle and leaves the whole register unchanged.
- R8: With `swap_en`, the register and the saved copy for level `swap_lvl` exchange contents in one cycle. Saved copies reset to 0, and the copies for other levels are not disturbed.
- R9: Only the highest-priority operation of a cycle acts. The order is swap, then raw write, then set-length, then set-maximum, then group size. `len_result` is 0 unless a set-length or set-maximum request is present, and `subvl_illegal` is raised only when the group-size request is the one that acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Raw full-word write |
| wr_data | input | 32 | Data for the raw write |
| setvl_en | input | 1 | Set-length request using `req_val` |
| setmvl_en | input | 1 | Set-maximum request using `req_val` |
| subvl_en | input | 1 | Group-size request using `req_val` |
| req_val | input | REQ_W | Requested length, maximum or group size |
| swap_en | input | 1 | Exchange with a saved copy (trap entry or return) |
| swap_lvl | input | LVL_W | Privilege level whose saved copy is exchanged |
| rdata | output | 32 | Current register contents |
| len_result | output | REQ_W | Granted length or maximum, returned to the destination register |
| subvl_illegal | output | 1 | Rejected group-size request, same cycle |

## Verification
There are two kinds of result. `len_result` and `subvl_illegal` are combinational, so they are due in the same cycle as the request. The register contents in `rdata` are due one clock edge after the request.

The driver applies each request at a falling edge and checks the combinational outputs one time unit later, before any clock edge. It then queues the register value its model expects. The monitor pops one queued value after each rising edge and compares it with `rdata`, so every request is matched with exactly the edge that commits it.

// File: rtl/vlst_pkg.sv
package vlst_pkg;

    // Register image, most significant field first.
    typedef struct packed {
        logic [3:0] rsvd;
        logic [1:0] dsv_off;
        logic [1:0] grp_code;
        logic [5:0] dst_off;
        logic [5:0] src_off;
        logic [5:0] len_m1;
        logic [5:0] max_m1;
    } vstate_t;

    localparam int FIELD_W = 6;
    localparam int CNT_W   = FIELD_W + 1;

    function automatic logic [FIELD_W-1:0] min_field(input logic [FIELD_W-1:0] a,
                                                     input logic [FIELD_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/vlst_len_clamp.sv
module vlst_len_clamp #(
    parameter int REQ_W = 32,
    parameter int CNT_W = 7
) (
    input  logic [REQ_W-1:0] req,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count
);
    logic [REQ_W-1:0] limit_ext;
    assign limit_ext = {{(REQ_W-CNT_W){1'b0}}, limit};

    always_comb begin
        if (req == '0)
            count = {{(CNT_W-1){1'b0}}, 1'b1};
        else if (req > limit_ext)
            count = limit;
        else
            count = req[CNT_W-1:0];
    end
endmodule

// File: rtl/vlst_grp_decode.sv
module vlst_grp_decode #(
    parameter int REQ_W = 32
) (
    input  logic [REQ_W-1:0] req,
    output logic             legal,
    output logic [1:0]       code
);
    logic [REQ_W-1:0] req_m1;

    assign req_m1 = req - {{(REQ_W-1){1'b0}}, 1'b1};
    assign legal  = (req != '0) && (req_m1 < REQ_W'(4));
    assign code   = req_m1[1:0];
endmodule

// File: rtl/vlst_save_bank.sv
module vlst_save_bank #(
    parameter int LEVELS = 4,
    parameter int W      = 32,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap_en,
    input  logic [LVL_W-1:0] swap_lvl,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     rd_data,
    output logic             hit
);
    logic [W-1:0] bank_q [LEVELS];
    logic [W-1:0] bank_d [LEVELS];

    assign hit     = (32'(swap_lvl) < LEVELS);
    assign rd_data = hit ? bank_q[swap_lvl] : '0;

    always_comb begin
        bank_d = bank_q;
        if (swap_en && hit)
            bank_d[swap_lvl] = wr_data;
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) bank_q[g] <= '0;
            else        bank_q[g] <= bank_d[g];
        end
    end

    // R8
    swap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && hit) |=> bank_q[$past(swap_lvl)] == $past(wr_data))
        else $error("saved copy not updated on swap");
endmodule

// File: rtl/vlst_state_csr.sv
module vlst_state_csr
    import vlst_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LEVELS = 4,
    parameter int REQ_W  = 32,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             setvl_en,
    input  logic             setmvl_en,
    input  logic             subvl_en,
    input  logic [REQ_W-1:0] req_val,
    input  logic             swap_en,
    input  logic [LVL_W-1:0] swap_lvl,
    output logic [31:0]      rdata,
    output logic [REQ_W-1:0] len_result,
    output logic             subvl_illegal
);
    localparam logic [CNT_W-1:0]   XLEN_CNT = CNT_W'(XLEN);
    localparam logic [FIELD_W-1:0] MAX_TOP  = FIELD_W'(XLEN - 1);

    vstate_t state_q, state_d;

    logic [CNT_W-1:0]   cur_max_cnt, vl_cnt, mx_cnt, sel_cnt;
    logic [FIELD_W-1:0] vl_m1, mx_m1, wr_max_f;
    logic               grp_ok, swap_go, swap_hit;
    logic [1:0]         grp_code;
    logic [31:0]        bank_rd;
    vstate_t            wr_view;

    assign cur_max_cnt = {1'b0, state_q.max_m1} + CNT_W'(1);

    vlst_len_clamp #(.REQ_W(REQ_W), .CNT_W(CNT_W)) u_vl_clamp (
        .req(req_val), .limit(cur_max_cnt), .count(vl_cnt));

    vlst_len_clamp #(.REQ_W(REQ_W), .CNT_W(CNT_W)) u_mx_clamp (
        .req(req_val), .limit(XLEN_CNT), .count(mx_cnt));

    vlst_grp_decode #(.REQ_W(REQ_W)) u_grp (
        .req(req_val), .legal(grp_ok), .code(grp_code));

    vlst_save_bank #(.LEVELS(LEVELS), .W(32)) u_bank (
        .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .swap_lvl(swap_lvl),
        .wr_data(state_q), .rd_data(bank_rd), .hit(swap_hit));

    assign swap_go  = swap_en && swap_hit;
    assign vl_m1    = FIELD_W'(vl_cnt - CNT_W'(1));
    assign mx_m1    = FIELD_W'(mx_cnt - CNT_W'(1));
    assign wr_view  = vstate_t'(wr_data);
    assign wr_max_f = min_field(wr_view.max_m1, MAX_TOP);

    always_comb begin
        state_d = state_q;
        if (swap_go) begin
            state_d = vstate_t'(bank_rd);
        end else if (wr_en) begin
            state_d        = wr_view;
            state_d.max_m1 = wr_max_f;
            state_d.len_m1 = min_field(wr_view.len_m1, wr_max_f);
            state_d.rsvd   = '0;
        end else if (setvl_en) begin
            state_d.len_m1 = vl_m1;
        end else if (setmvl_en) begin
            state_d.max_m1 = mx_m1;
            state_d.len_m1 = min_field(state_q.len_m1, mx_m1);
        end else if (subvl_en && grp_ok) begin
            state_d.grp_code = grp_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sel_cnt       = setvl_en ? vl_cnt : (setmvl_en ? mx_cnt : '0);
    assign len_result    = {{(REQ_W-CNT_W){1'b0}}, sel_cnt};
    assign subvl_illegal = subvl_en && !swap_en && !wr_en && !setvl_en
                           && !setmvl_en && !grp_ok;
    assign rdata         = state_q;

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[31:28] == 4'd0) else $error("reserved bits nonzero");

    // R6
    vl_within_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[11:6] <= rdata[5:0]) else $error("length above maximum");

    // R5
    max_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[5:0] <= MAX_TOP) else $error("maximum above XLEN");

    // R3
    setvl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_en && !swap_go && !wr_en) |=>
            ({1'b0, rdata[11:6]} + CNT_W'(1)) == $past(len_result[CNT_W-1:0]))
        else $error("granted length not committed");

    // R7
    subvl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        subvl_illegal |=> $stable(rdata)) else $error("rejected group size changed state");
endmodule

// File: tb/vlst_state_csr_tb_top.sv
`timescale 1ns/1ps
module vlst_state_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, setvl_en = 1'b0, setmvl_en = 1'b0, subvl_en = 1'b0, swap_en = 1'b0;
    logic [31:0] wr_data = '0, req_val = '0;
    logic [1:0]  swap_lvl = '0;
    logic [31:0] rdata, len_result;
    logic        subvl_illegal;

    always #2.5 clk = ~clk;

    vlst_state_csr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .setvl_en(setvl_en), .setmvl_en(setmvl_en), .subvl_en(subvl_en),
        .req_val(req_val), .swap_en(swap_en), .swap_lvl(swap_lvl),
        .rdata(rdata), .len_result(len_result), .subvl_illegal(subvl_illegal));

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // model state
    int m_max = 1, m_len = 1, m_src = 0, m_dst = 0, m_grp = 0, m_dsv = 0;
    logic [31:0] m_saved [4] = '{default: '0};

    logic [31:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [31:0] pack_model();
        return {4'b0, 2'(m_dsv), 2'(m_grp), 6'(m_dst), 6'(m_src), 6'(m_len - 1), 6'(m_max - 1)};
    endfunction

    task automatic unpack_model(input logic [31:0] v);
        m_max = int'(v[5:0]) + 1;
        m_len = int'(v[11:6]) + 1;
        m_src = int'(v[17:12]);
        m_dst = int'(v[23:18]);
        m_grp = int'(v[25:24]);
        m_dsv = int'(v[27:26]);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // driver: one request per clock
    task automatic step(input bit sw, input logic [1:0] lvl, input bit we, input logic [31:0] wd,
                        input bit sv, input bit sm, input bit sb, input logic [31:0] rq,
                        input string tag);
        int exp_res, vl_g, mx_g, mf, vf;
        bit grp_legal, exp_ill;
        logic [31:0] tmp;
        @(negedge clk);
        swap_en = sw; swap_lvl = lvl; wr_en = we; wr_data = wd;
        setvl_en = sv; setmvl_en = sm; subvl_en = sb; req_val = rq;
        #1;
        vl_g = (rq == 0) ? 1 : ((rq > 32'(m_max)) ? m_max : int'(rq));
        mx_g = (rq == 0) ? 1 : ((rq > 32) ? 32 : int'(rq));
        grp_legal = (rq >= 1) && (rq <= 4);
        exp_res = sv ? vl_g : (sm ? mx_g : 0);
        exp_ill = sb && !sw && !we && !sv && !sm && !grp_legal;
        check(len_result, 32'(exp_res), {tag, " len_result"});
        check(32'(subvl_illegal), 32'(exp_ill), {tag, " subvl_illegal"});
        if (sw) begin
            tmp = pack_model();
            unpack_model(m_saved[lvl]);
            m_saved[lvl] = tmp;
        end else if (we) begin
            mf = (wd[5:0] > 31) ? 31 : int'(wd[5:0]);
            vf = (int'(wd[11:6]) > mf) ? mf : int'(wd[11:6]);
            m_max = mf + 1; m_len = vf + 1;
            m_src = int'(wd[17:12]); m_dst = int'(wd[23:18]);
            m_grp = int'(wd[25:24]); m_dsv = int'(wd[27:26]);
        end else if (sv) begin
            m_len = vl_g;
        end else if (sm) begin
            m_max = mx_g;
            if (m_len > m_max) m_len = m_max;
        end else if (sb && grp_legal) begin
            m_grp = int'(rq) - 1;
        end
        exp_q.push_back(pack_model());
        tag_q.push_back({tag, " rdata"});
    endtask

    task automatic idle();
        @(negedge clk);
        swap_en = 0; wr_en = 0; setvl_en = 0; setmvl_en = 0; subvl_en = 0; req_val = '0;
    endtask

    // monitor: compare committed register one edge after each request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rdata, 32'h0, "R2 reset rdata");
        check(len_result, 32'h0, "R2 reset len_result");
        check(32'(subvl_illegal), 32'h0, "R2 reset illegal");

        step(0, 0, 0, 0, 1, 0, 0, 5,   "R3 setvl above max 1");
        step(0, 0, 0, 0, 0, 1, 0, 16,  "R5 setmvl 16");
        step(0, 0, 0, 0, 1, 0, 0, 5,   "R3 setvl 5");
        step(0, 0, 0, 0, 1, 0, 0, 40,  "R3 setvl clamp 40");
        step(0, 0, 0, 0, 1, 0, 0, 0,   "R4 setvl zero");
        step(0, 0, 0, 0, 0, 1, 0, 100, "R5 setmvl above XLEN");
        step(0, 0, 0, 0, 1, 0, 0, 32,  "R3 setvl 32");
        step(0, 0, 0, 0, 0, 1, 0, 8,   "R5 setmvl shrinks length");
        step(0, 0, 0, 0, 0, 1, 0, 0,   "R5 setmvl zero");
        step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R6 R1 write all ones");
        step(0, 0, 1, 32'h0A5B_3283, 0, 0, 0, 0, "R6 length above max field");
        step(0, 0, 1, 32'h0912_3C47, 0, 0, 0, 0, "R1 field layout");
        for (int g = 1; g <= 4; g++)
            step(0, 0, 0, 0, 0, 0, 1, 32'(g), "R7 group size legal");
        step(0, 0, 0, 0, 0, 0, 1, 0,   "R7 group size 0 illegal");
        step(0, 0, 0, 0, 0, 0, 1, 5,   "R7 group size 5 illegal");
        step(0, 0, 0, 0, 0, 0, 1, 32'h1_0002, "R7 group size wide illegal");
        step(1, 1, 0, 0, 0, 0, 0, 0,   "R8 swap into level 1");
        step(0, 0, 0, 0, 0, 1, 0, 12,  "R8 setmvl after swap");
        step(1, 2, 0, 0, 0, 0, 0, 0,   "R8 swap into level 2");
        step(1, 1, 0, 0, 0, 0, 0, 0,   "R8 swap back level 1");
        step(1, 2, 0, 0, 0, 0, 0, 0,   "R8 swap back level 2");
        step(1, 3, 1, 32'h0000_0041, 1, 0, 1, 9, "R9 swap beats write");
        step(0, 0, 1, 32'h0000_0105, 1, 0, 0, 2, "R9 write beats setvl");
        step(0, 0, 0, 0, 1, 1, 0, 4,   "R9 setvl beats setmvl");
        step(0, 0, 0, 0, 0, 1, 1, 7,   "R9 setmvl masks illegal group");
        step(1, 3, 0, 0, 0, 0, 0, 0,   "R8 swap level 3 back");
        idle();
        @(negedge clk);
        check(32'(exp_q.size()), 32'h0, "R9 all results observed");
        finish_up();
    end
endmodule